// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Controller

This block is a 32-pin general-purpose I/O port with a word-addressed register file. Software sets a per-pin output value and a per-pin drive enable, reads back the live pad levels, and picks for every pin the condition that raises an interrupt: low level, high level, rising edge, falling edge, or both edges. Pad inputs are first passed through a two-flop synchronizer. Edges are found by comparing the synchronized level with its copy from one cycle earlier.

Detected events set bits in a sticky status register, which software clears by writing ones. A mask register decides which pending bits reach the interrupt outputs. There are three outputs: one for the lower sixteen pins, one for the upper sixteen, and one that covers every pin.

The register bus is a single-cycle write with a combinational read. The register is chosen by byte address (word index = address / 4). Writes take effect at the clock edge where the write enable is high.

Top module: `gpio_irq_port`

## Requirements
- R1: When reset is released, every register reads zero and padOut, padOe and the three interrupt outputs are all 0.
- R2: padOut always follows the output-data register (offset 0x00) and padOe follows the direction register (offset 0x04), where 1 means drive. Reading either offset returns the value last written to it.
- R3: Offset 0x08 returns the pad levels after two register stages, so a pad change becomes visible after the second rising clock edge. Writes to 0x08 are ignored.
- R4: The 2-bit trigger field for pin p is at bits [2*(p mod 16)+1 : 2*(p mod 16)]. That bit range is in the low config register (0x0C) for p < 16 and in the high config register (0x10) for p >= 16.
- R5: Trigger code 00 (low level) and code 01 (high level) set the status bit on every cycle the synchronized level matches. While the condition holds, a clear has no lasting effect.
- R6: Trigger code 10 sets the status bit once, on a synchronized rising edge. Trigger code 11 sets it once, on a falling edge. After a pad change the bit becomes readable after the third rising clock edge. An edge of the other direction does nothing.
- R7: A 1 in the both-edge register (0x1C) makes that pin's status bit set on either edge. The pin's trigger field is then ignored.
- R8: In the status register (0x18), writing 1 to a bit clears it and writing 0 leaves it unchanged. A bit that is not cleared stays set.
- R9: Status bits are set whatever the mask says. The mask register (0x14) only gates the interrupt outputs, and a mask bit of 1 enables its pin.
- R10: irqLow is high when some pin 0-15 is both pending and enabled. irqHigh does the same for pins 16-31. irqAll is high when any pin is pending and enabled.
- R11: Reads of offsets 0x20 and above return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 6 | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| padIn | input | 32 | Pad input levels, asynchronous |
| padOut | output | 32 | Output value to the pads |
| padOe | output | 32 | Per-pin output enable |
| irqAll | output | 1 | Interrupt for all pins |
| irqLow | output | 1 | Interrupt for pins 0-15 |
| irqHigh | output | 1 | Interrupt for pins 16-31 |

## Verification
The bench builds the port with its default parameters: 32 pins, a two-stage synchronizer and a 6-bit byte address. With those values the register map is complete, and both halves of the split interrupt can be driven. Boundary pins are included, such as pin 17 and pin 20, whose fields sit in the high config register, and pin 30 on the upper interrupt line. The synchronizer depth fixes the latency that the bench checks, which is two edges for pad readback and three for a status bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Per-register write strobes produced by the decoder.
  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic cfgLoWr;
    logic cfgHiWr;
    logic maskWr;
    logic statClr;
    logic bothWr;
  } regStrobe_t;

  typedef enum logic [3:0] {
    SEL_DATA  = 4'd0,
    SEL_DIR   = 4'd1,
    SEL_PAD   = 4'd2,
    SEL_CFGLO = 4'd3,
    SEL_CFGHI = 4'd4,
    SEL_MASK  = 4'd5,
    SEL_STAT  = 4'd6,
    SEL_BOTH  = 4'd7,
    SEL_NONE  = 4'd8
  } readSel_t;

  localparam logic [1:0] TRIG_LOW  = 2'b00;
  localparam logic [1:0] TRIG_HIGH = 2'b01;
  localparam logic [1:0] TRIG_RISE = 2'b10;
  localparam logic [1:0] TRIG_FALL = 2'b11;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe,
  output readSel_t          rdSel
);

  logic [ADDR_W-1:0] wordIdx;
  assign wordIdx = busAddr >> 2;

  always_comb begin
    rdSel = SEL_NONE;
    case (wordIdx)
      ADDR_W'(0): rdSel = SEL_DATA;
      ADDR_W'(1): rdSel = SEL_DIR;
      ADDR_W'(2): rdSel = SEL_PAD;
      ADDR_W'(3): rdSel = SEL_CFGLO;
      ADDR_W'(4): rdSel = SEL_CFGHI;
      ADDR_W'(5): rdSel = SEL_MASK;
      ADDR_W'(6): rdSel = SEL_STAT;
      ADDR_W'(7): rdSel = SEL_BOTH;
      default:    rdSel = SEL_NONE;
    endcase
  end

  // The pad-status slot has no strobe, so writes to it are dropped.
  always_comb begin
    strobe         = '0;
    strobe.dataWr  = busWrEn && (rdSel == SEL_DATA);
    strobe.dirWr   = busWrEn && (rdSel == SEL_DIR);
    strobe.cfgLoWr = busWrEn && (rdSel == SEL_CFGLO);
    strobe.cfgHiWr = busWrEn && (rdSel == SEL_CFGHI);
    strobe.maskWr  = busWrEn && (rdSel == SEL_MASK);
    strobe.statClr = busWrEn && (rdSel == SEL_STAT);
    strobe.bothWr  = busWrEn && (rdSel == SEL_BOTH);
  end

  // R11: at most one register is written per cycle; none for unmapped offsets
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PIN_COUNT-1:0]   padIn,
  input  logic [2*PIN_COUNT-1:0] trigCfg,
  input  logic [PIN_COUNT-1:0]   bothSel,
  output logic [PIN_COUNT-1:0]   padNow,
  output logic [PIN_COUNT-1:0]   eventVec
);

  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [PIN_COUNT-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign padNow = syncQ[SYNC_STAGES-1];

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic riseSeen;
    logic fallSeen;
    logic evBit;
    assign riseSeen = padNow[p] & ~prevQ[p];
    assign fallSeen = ~padNow[p] & prevQ[p];
    always_comb begin
      if (bothSel[p]) begin
        evBit = riseSeen | fallSeen;
      end else begin
        case (trigCfg[2*p +: 2])
          TRIG_LOW:  evBit = ~padNow[p];
          TRIG_HIGH: evBit = padNow[p];
          TRIG_RISE: evBit = riseSeen;
          default:   evBit = fallSeen;
        endcase
      end
    end
    assign eventVec[p] = evBit;
  end

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  regStrobe_t           strobe,
  input  readSel_t             rdSel,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqAll,
  output logic                 irqLow,
  output logic                 irqHigh
);

  localparam int HALF = PIN_COUNT / 2;

  logic [PIN_COUNT-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ, maskQ, statQ, bothQ;
  logic [PIN_COUNT-1:0] padNow, eventVec, clrVec, pendVec;

  gpio_irq_detect #(
    .PIN_COUNT  (PIN_COUNT),
    .SYNC_STAGES(SYNC_STAGES)
  ) detect_i (
    .clk     (clk),
    .rst     (rst),
    .padIn   (padIn),
    .trigCfg ({cfgHiQ, cfgLoQ}),
    .bothSel (bothQ),
    .padNow  (padNow),
    .eventVec(eventVec)
  );

  assign clrVec = strobe.statClr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ  <= '0;
      dirQ   <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '0;
      statQ  <= '0;
      bothQ  <= '0;
    end else begin
      if (strobe.dataWr)  dataQ  <= wrData;
      if (strobe.dirWr)   dirQ   <= wrData;
      if (strobe.cfgLoWr) cfgLoQ <= wrData;
      if (strobe.cfgHiWr) cfgHiQ <= wrData;
      if (strobe.maskWr)  maskQ  <= wrData;
      if (strobe.bothWr)  bothQ  <= wrData;
      // A new event wins over a clear in the same cycle.
      statQ <= (statQ & ~clrVec) | eventVec;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_DATA:  rdData = dataQ;
      SEL_DIR:   rdData = dirQ;
      SEL_PAD:   rdData = padNow;
      SEL_CFGLO: rdData = cfgLoQ;
      SEL_CFGHI: rdData = cfgHiQ;
      SEL_MASK:  rdData = maskQ;
      SEL_STAT:  rdData = statQ;
      SEL_BOTH:  rdData = bothQ;
      default:   rdData = '0;
    endcase
  end

  assign padOut  = dataQ;
  assign padOe   = dirQ;
  assign pendVec = statQ & maskQ;
  assign irqLow  = |pendVec[HALF-1:0];
  assign irqHigh = |pendVec[PIN_COUNT-1:HALF];
  assign irqAll  = |pendVec;

  // R8: pending bits that were not cleared remain pending
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statQ & $past(statQ & ~clrVec)) == $past(statQ & ~clrVec)));

  // R5: a status bit only rises when the detector reported an event
  assert_set_needs_event_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statQ & ~$past(statQ) & ~$past(eventVec)) == '0));

  // R2: output data changes only on its own write strobe
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobe.dataWr |=> $stable(dataQ));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [PIN_COUNT-1:0] busWrData,
  output logic [PIN_COUNT-1:0] busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqAll,
  output logic                 irqLow,
  output logic                 irqHigh
);

  regStrobe_t strobe;
  readSel_t   rdSel;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  gpio_irq_datapath #(
    .PIN_COUNT  (PIN_COUNT),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rdSel  (rdSel),
    .wrData (busWrData),
    .padIn  (padIn),
    .rdData (busRdData),
    .padOut (padOut),
    .padOe  (padOe),
    .irqAll (irqAll),
    .irqLow (irqLow),
    .irqHigh(irqHigh)
  );

endmodule

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;

  localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_PAD = 6'h08,
    A_CFGLO = 6'h0C, A_CFGHI = 6'h10, A_MASK = 6'h14, A_STAT = 6'h18,
    A_BOTH = 6'h1C;
  localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  busAddr;
  logic        busWrEn;
  logic [31:0] busWrData, busRdData, padIn, padOut, padOe;
  logic        irqAll, irqLow, irqHigh;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqAll(irqAll), .irqLow(irqLow),
    .irqHigh(irqHigh)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setPad(input logic [31:0] v);
    @(negedge clk);
    padIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic expectStat(input string req, input logic [31:0] exp);
    logic [31:0] d;
    busRead(A_STAT, d);
    check(req, d, exp);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(A_DATA, d); check("R1 data", d, 0);
    busRead(A_STAT, d); check("R1 status", d, 0);
    busRead(A_CFGLO, d); check("R1 cfglo", d, 0);
    check("R1 pads", {padOut | padOe}, 0);
    check("R1 irq", {29'd0, irqAll, irqLow, irqHigh}, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    busWrite(A_DATA, 32'h1234_5678);
    busWrite(A_DIR, 32'hF0F0_F0F0);
    check("R2 padOut", padOut, 32'h1234_5678);
    check("R2 padOe", padOe, 32'hF0F0_F0F0);
    busRead(A_DATA, d); check("R2 data read", d, 32'h1234_5678);
    busRead(A_DIR, d);  check("R2 dir read", d, 32'hF0F0_F0F0);
    busRead(A_CFGLO, d); check("R4 cfglo read", d, ALL_RISE);
    busRead(6'h20, d); check("R11 read 0x20", d, 0);
    busRead(6'h3C, d); check("R11 read 0x3C", d, 0);
    busWrite(6'h24, 32'hFFFF_FFFF);
    busRead(A_DATA, d); check("R11 data untouched", d, 32'h1234_5678);
    busRead(A_MASK, d); check("R11 mask untouched", d, 0);
    check("R11 irq idle", {31'd0, irqAll}, 0);
  endtask

  task automatic testPadStatus();
    logic [31:0] d;
    @(negedge clk);
    padIn = 32'hA5A5_0000;
    @(negedge clk);
    busRead(A_PAD, d); check("R3 one edge", d, 0);
    @(negedge clk);
    busRead(A_PAD, d); check("R3 two edges", d, 32'hA5A5_0000);
    busWrite(A_PAD, 32'hFFFF_FFFF);
    busRead(A_PAD, d); check("R3 write ignored", d, 32'hA5A5_0000);
    setPad(0);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    expectStat("R3 cleanup", 0);
  endtask

  task automatic testLevelHigh();
    busWrite(A_CFGLO, 32'hAAAA_AA6A); // pin 3 field [7:6] = 01
    busWrite(A_STAT, 32'hFFFF_FFFF);
    expectStat("R5 high idle", 0);
    setPad(32'h8);
    expectStat("R5 high set", 32'h8);
    busWrite(A_STAT, 32'h8);
    expectStat("R5 clear while held", 32'h8);
    setPad(0);
    busWrite(A_STAT, 32'h8);
    expectStat("R5 clear after release", 0);
    busWrite(A_CFGLO, ALL_RISE);
  endtask

  task automatic testLevelLow();
    setPad(32'h0010_0000);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    busWrite(A_CFGHI, 32'hAAAA_A8AA); // pin 20 field [9:8] = 00
    repeat (3) @(negedge clk);
    expectStat("R4 R5 low idle", 0);
    setPad(0);
    expectStat("R4 R5 low set", 32'h0010_0000);
    busWrite(A_STAT, 32'h0010_0000);
    expectStat("R5 low held", 32'h0010_0000);
    setPad(32'h0010_0000);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    expectStat("R5 low cleared", 0);
    busWrite(A_CFGHI, ALL_RISE);
    setPad(0);
    busWrite(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic testRise();
    @(negedge clk);
    padIn = 32'h20;
    repeat (2) @(negedge clk);
    expectStat("R6 rise after two edges", 0);
    @(negedge clk);
    expectStat("R6 rise after three edges", 32'h20);
    busWrite(A_STAT, 32'h20);
    repeat (3) @(negedge clk);
    expectStat("R6 rise single shot", 0);
    setPad(0);
    expectStat("R6 fall ignored", 0);
  endtask

  task automatic testFall();
    busWrite(A_CFGHI, 32'hAAAA_AAAE); // pin 17 field [3:2] = 11
    setPad(32'h0002_0000);
    expectStat("R6 R4 rise ignored", 0);
    setPad(0);
    expectStat("R6 R4 fall set", 32'h0002_0000);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    busWrite(A_CFGHI, ALL_RISE);
  endtask

  task automatic testBoth();
    busWrite(A_BOTH, 32'h200);
    busWrite(A_CFGLO, 32'hAAA2_AAAA); // pin 9 field = 00, overridden
    repeat (3) @(negedge clk);
    expectStat("R7 field ignored", 0);
    setPad(32'h200);
    expectStat("R7 rise", 32'h200);
    busWrite(A_STAT, 32'h200);
    expectStat("R7 cleared", 0);
    setPad(0);
    expectStat("R7 fall", 32'h200);
    busWrite(A_CFGLO, ALL_RISE);
    busWrite(A_BOTH, 0);
    busWrite(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic testMaskIrq();
    setPad(32'h4);
    expectStat("R9 set while masked", 32'h4);
    check("R9 masked irq", {29'd0, irqAll, irqLow, irqHigh}, 0);
    busWrite(A_STAT, 0);
    expectStat("R8 write zero", 32'h4);
    busWrite(A_MASK, 32'h4);
    check("R10 low half", {29'd0, irqAll, irqLow, irqHigh}, 3'b110);
    setPad(32'h4000_0004);
    expectStat("R9 both pending", 32'h4000_0004);
    check("R10 high masked", {31'd0, irqHigh}, 0);
    busWrite(A_STAT, 32'h4);
    check("R10 after low clear", {29'd0, irqAll, irqLow, irqHigh}, 0);
    busWrite(A_MASK, 32'h4000_0000);
    check("R10 high half", {29'd0, irqAll, irqLow, irqHigh}, 3'b101);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    check("R8 all cleared irq", {29'd0, irqAll, irqLow, irqHigh}, 0);
    expectStat("R8 all cleared", 0);
    setPad(0);
    busWrite(A_MASK, 0);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; busAddr = '0; busWrEn = 1'b0; busWrData = '0; padIn = '0;
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    busWrite(A_CFGLO, ALL_RISE);
    busWrite(A_CFGHI, ALL_RISE);
    busWrite(A_STAT, 32'hFFFF_FFFF);
    expectStat("R8 initial clear", 0);
    testRegs();
    testPadStatus();
    testLevelHigh();
    testLevelLow();
    testRise();
    testFall();
    testBoth();
    testMaskIrq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule